// File: doc/BRIEF.md
# CMI Line Encoder with Violation Injection

This block turns a serial NRZ bit stream into Coded Mark Inversion line symbols. It runs on a single clock at twice the line bit rate. A bit-rate enable, high on every second cycle, marks the edge where an input bit is taken in. Each input bit then leaves as two half-bit chips on the line output, over the two cycles that follow. A zero becomes a low-then-high pair. A one becomes a steady level, and that level flips from one mark to the next.

A mode input selects CMI coding or plain NRZ pass-through. In NRZ mode both chips equal the input bit, so the line carries the input delayed by one bit. For diagnostics, a violation request may be raised on any sampled bit, or held over a run of bits. A violated zero goes out with its halves swapped. A violated one repeats the level of the previous mark. The mark-level state follows the level actually sent, so a single violation never causes a train of further errors.

A registered status output is high only when the output enable is on, CMI mode is selected and reset is released. An active-low reset holds the line and the status low.

Top module: `cmi_line_encoder`

## Requirements
- R1: `bit_en_i` is high on one cycle of every two. At a rising edge where it is high, the symbol for `data_i` is captured. Its first chip shows on `line_o` for the cycle after that edge, and its second chip for the cycle after that.
- R2: In CMI mode (`cmi_mode_i`=1), a zero bit without violation is sent as chip 0 then chip 1.
- R3: In CMI mode, a one bit is sent as the same level on both chips.
- R4: Without violations, successive ones in CMI mode alternate in level. The mark-level state resets to low, so the first one after reset is sent high.
- R5: In NRZ mode (`cmi_mode_i`=0), both chips equal the input bit. This makes `line_o` a one-bit-delayed copy of the input. The mark-level state does not change in this mode.
- R6: In CMI mode, a zero bit with `viol_req_i`=1 is sent as chip 1 then chip 0.
- R7: In CMI mode, a one bit with `viol_req_i`=1 repeats the level of the previous one, and the next normal one is the inverse of the level actually sent. Holding `viol_req_i` high violates every bit sampled.
- R8: `viol_req_i` has no effect in NRZ mode.
- R9: One cycle after each edge, `status_o` equals `out_en_i` AND `cmi_mode_i` as sampled at that edge.
- R10: While `rst_ni` is low, `line_o` and `status_o` are low, and the mark-level state returns to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock at twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-rate strobe, high on one cycle in two |
| data_i | input | 1 | Serial NRZ data bit |
| cmi_mode_i | input | 1 | 1 = CMI coding, 0 = NRZ pass-through |
| viol_req_i | input | 1 | Request a code violation on the sampled bit |
| out_en_i | input | 1 | Output enable reported in status |
| line_o | output | 1 | Encoded line chip stream |
| status_o | output | 1 | High when enabled, in CMI mode and out of reset |

## Verification
A bit captured at a strobe edge shows its first chip in the cycle after that edge and its second chip one cycle later. The bench therefore reads both chips at the two falling edges that follow the capturing rising edge, and it presents the next bit at the second of those falling edges. `status_o` is due one cycle after its inputs change, so the bench reads it at the falling edge after one rising edge. Reset acts asynchronously, so the reset checks are taken while reset is still low.

// File: rtl/cmi_enc_pkg.sv
package cmi_enc_pkg;

    // Number of half-bit chips emitted per input bit.
    localparam int unsigned CHIPS_PER_BIT = 2;
    localparam int unsigned TAIL_W        = CHIPS_PER_BIT - 1;

    // A symbol: MSB is the first chip sent on the line.
    typedef logic [CHIPS_PER_BIT-1:0] cmi_symbol_t;

    // Fixed code shapes for a zero bit.
    localparam cmi_symbol_t ZERO_NORMAL   = 2'b01;
    localparam cmi_symbol_t ZERO_VIOLATED = 2'b10;

    typedef enum logic {
        MODE_NRZ = 1'b0,
        MODE_CMI = 1'b1
    } line_mode_e;

endpackage

// File: rtl/cmi_symbol_map.sv
module cmi_symbol_map
    import cmi_enc_pkg::*;
(
    input  logic        bit_i,
    input  logic        viol_i,
    input  logic        cmi_mode_i,
    input  logic        level_q_i,
    output cmi_symbol_t symbol_o,
    output logic        level_d_o
);

    logic mark_level;

    always_comb begin
        symbol_o   = '0;
        level_d_o  = level_q_i;
        mark_level = ~level_q_i;
        if (line_mode_e'(cmi_mode_i) == MODE_NRZ) begin
            // Pass-through: every chip is the data bit; violation ignored.
            symbol_o = {CHIPS_PER_BIT{bit_i}};
        end else if (!bit_i) begin
            symbol_o = viol_i ? ZERO_VIOLATED : ZERO_NORMAL;
        end else begin
            // A violated mark repeats the last sent level.
            mark_level = viol_i ? level_q_i : ~level_q_i;
            symbol_o   = {CHIPS_PER_BIT{mark_level}};
            level_d_o  = mark_level;
        end
    end

endmodule

// File: rtl/cmi_level_tracker.sv
module cmi_level_tracker #(
    parameter logic INIT_LEVEL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic level_d_i,
    output logic level_q_o
);

    typedef struct packed {
        logic level;
    } trk_state_t;

    trk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.level = level_d_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.level <= INIT_LEVEL;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_q_o = st_q.level;

endmodule

// File: rtl/cmi_chip_shifter.sv
module cmi_chip_shifter
    import cmi_enc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        load_i,
    input  cmi_symbol_t symbol_i,
    output logic        line_o
);

    typedef struct packed {
        logic              line;
        logic [TAIL_W-1:0] tail;
    } shf_state_t;

    shf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.line = symbol_i[CHIPS_PER_BIT-1];
            st_d.tail = symbol_i[TAIL_W-1:0];
        end else begin
            st_d.line = st_q.tail[TAIL_W-1];
            st_d.tail = st_q.tail << 1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;

endmodule

// File: rtl/cmi_status_reg.sv
module cmi_status_reg (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic out_en_i,
    input  logic cmi_mode_i,
    output logic status_o
);

    typedef struct packed {
        logic ok;
    } sts_state_t;

    sts_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ok = out_en_i & cmi_mode_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.ok;

endmodule

// File: rtl/cmi_line_encoder.sv
module cmi_line_encoder
    import cmi_enc_pkg::*;
#(
    parameter logic MARK_INIT_LEVEL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bit_en_i,
    input  logic data_i,
    input  logic cmi_mode_i,
    input  logic viol_req_i,
    input  logic out_en_i,
    output logic line_o,
    output logic status_o
);

    cmi_symbol_t symbol;
    logic        level_q;
    logic        level_d;

    cmi_symbol_map u_map (
        .bit_i      (data_i),
        .viol_i     (viol_req_i),
        .cmi_mode_i (cmi_mode_i),
        .level_q_i  (level_q),
        .symbol_o   (symbol),
        .level_d_o  (level_d)
    );

    cmi_level_tracker #(
        .INIT_LEVEL (MARK_INIT_LEVEL)
    ) u_trk (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (bit_en_i),
        .level_d_i (level_d),
        .level_q_o (level_q)
    );

    cmi_chip_shifter u_shf (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (bit_en_i),
        .symbol_i (symbol),
        .line_o   (line_o)
    );

    cmi_status_reg u_sts (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .out_en_i   (out_en_i),
        .cmi_mode_i (cmi_mode_i),
        .status_o   (status_o)
    );

endmodule

// File: rtl/cmi_line_encoder_checker.sv
module cmi_line_encoder_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic bit_en_i,
    input logic data_i,
    input logic cmi_mode_i,
    input logic viol_req_i,
    input logic out_en_i,
    input logic line_o,
    input logic status_o
);

    // R1: strobe never high on two cycles in a row
    p_strobe_spacing_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_en_i |=> !bit_en_i);

    // R2: plain zero is low then high
    p_zero_shape_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && cmi_mode_i && !data_i && !viol_req_i) |=> !line_o ##1 line_o);

    // R3: a mark keeps one level for both chips
    p_mark_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && cmi_mode_i && data_i) |=> ##1 (line_o == $past(line_o)));

    // R5: NRZ pass-through copies the bit onto both chips
    p_nrz_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && !cmi_mode_i) |=> (line_o == $past(data_i)) ##1 (line_o == $past(data_i, 2)));

    // R6: violated zero is high then low
    p_zero_violated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_en_i && cmi_mode_i && !data_i && viol_req_i) |=> line_o ##1 !line_o);

    // R9: status follows enable and mode one cycle later
    p_status_follow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni |=> (status_o == $past(out_en_i && cmi_mode_i)));

    // R10: outputs low during reset
    always @(negedge clk_i) begin
        if (!rst_ni) begin
            p_reset_quiet_r10: assert (!line_o && !status_o);
        end
    end

endmodule

bind cmi_line_encoder cmi_line_encoder_checker u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_en_i   (bit_en_i),
    .data_i     (data_i),
    .cmi_mode_i (cmi_mode_i),
    .viol_req_i (viol_req_i),
    .out_en_i   (out_en_i),
    .line_o     (line_o),
    .status_o   (status_o)
);

// File: tb/cmi_line_encoder_bench.sv
module cmi_line_encoder_bench;

    logic clk_i = 1'b0;
    logic rst_ni;
    logic bit_en_i = 1'b0;
    logic data_i = 1'b0;
    logic cmi_mode_i = 1'b1;
    logic viol_req_i = 1'b0;
    logic out_en_i = 1'b0;
    logic line_o;
    logic status_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk_i = ~clk_i;

    cmi_line_encoder u_cmi_line_encoder (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bit_en_i   (bit_en_i),
        .data_i     (data_i),
        .cmi_mode_i (cmi_mode_i),
        .viol_req_i (viol_req_i),
        .out_en_i   (out_en_i),
        .line_o     (line_o),
        .status_o   (status_o)
    );

    // Fields: {mode, viol, data, chip0, chip1}; expected values from R2..R8,
    // mark level starts low after reset (R4).
    localparam int NV = 18;
    localparam logic [4:0] VEC [NV] = '{
        5'b1_0_0_01,   // R2 zero
        5'b1_0_1_11,   // R4 first mark high
        5'b1_0_1_00,   // R4 alternate
        5'b1_0_0_01,   // R2
        5'b1_0_1_11,   // R3
        5'b1_1_1_11,   // R7 violated mark repeats high
        5'b1_0_1_00,   // R7 next mark inverts sent level
        5'b1_1_0_10,   // R6 violated zero
        5'b1_1_1_00,   // R7 held request: repeat low
        5'b1_1_1_00,   // R7 held request again
        5'b1_0_1_11,   // R7 recovery
        5'b0_0_1_11,   // R5 NRZ one
        5'b0_0_0_00,   // R5 NRZ zero
        5'b0_1_0_00,   // R8 request ignored
        5'b0_1_1_11,   // R8 request ignored
        5'b1_0_1_00,   // R5 level unchanged by NRZ bits
        5'b1_0_0_01,   // R2
        5'b1_0_1_11    // R4
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Present one bit at a falling edge, read both chips afterwards.
    task automatic send_bit(input logic mode, input logic viol, input logic d,
                            input logic e0, input logic e1, input string req);
        cmi_mode_i = mode;
        viol_req_i = viol;
        data_i     = d;
        bit_en_i   = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        bit_en_i = 1'b0;
        check({req, " chip0"}, line_o, e0);
        @(posedge clk_i);
        @(negedge clk_i);
        check({req, " chip1"}, line_o, e1);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_ni = 1'b1;
        #1 rst_ni = 1'b0;
        out_en_i = 1'b1;
        repeat (3) @(negedge clk_i);
        check("R10 line in reset", line_o, 1'b0);
        check("R10 status in reset", status_o, 1'b0);
        rst_ni = 1'b1;

        for (int i = 0; i < NV; i++) begin
            send_bit(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0],
                     $sformatf("R1 vector %0d", i));
        end

        // R9: status tracking
        cmi_mode_i = 1'b1; out_en_i = 1'b1;
        @(posedge clk_i); @(negedge clk_i);
        check("R9 enabled cmi", status_o, 1'b1);
        out_en_i = 1'b0;
        @(posedge clk_i); @(negedge clk_i);
        check("R9 disabled", status_o, 1'b0);
        out_en_i = 1'b1; cmi_mode_i = 1'b0;
        @(posedge clk_i); @(negedge clk_i);
        check("R9 nrz mode", status_o, 1'b0);
        cmi_mode_i = 1'b1;
        @(posedge clk_i); @(negedge clk_i);
        check("R9 back on", status_o, 1'b1);

        // R10: reset mid-stream after a high mark, then level starts low again
        send_bit(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4 mark before reset");
        send_bit(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R4 mark before reset");
        cmi_mode_i = 1'b1; data_i = 1'b1; bit_en_i = 1'b1;
        @(posedge clk_i);
        #2 rst_ni = 1'b0;
        bit_en_i = 1'b0;
        @(negedge clk_i);
        check("R10 line cleared", line_o, 1'b0);
        check("R10 status cleared", status_o, 1'b0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        send_bit(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R10 level reset");
        send_bit(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R2 after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule